// File: doc/BRIEF.md
# Interlaced Field Retrace Selector

An interlaced camera produces two vertical retrace intervals per image, one per field. A pattern loader that works once per image needs only one of them. This block takes the camera's active-low vertical sync and an optional odd/even field input. It synchronizes both to the system clock and rejects short low glitches on the sync line. It then tracks which field each retrace belongs to and passes only the retrace of the field chosen by a static select. At a 30 Hz frame rate the output therefore recurs every 1/30 s, once per full frame.

The field can come from the block's own tracker or from an external field signal. The tracker is a toggle that flips on every accepted retrace and is cleared by reset. A retrace is accepted once the synchronized sync has stayed low longer than a programmable number of clocks. The output is then high for the remainder of that retrace interval, for the selected field only.

The control is a four-state machine:
- `ST_WAIT`: idle, sync high.
- `ST_QUAL`: sync low, counting toward the minimum.
- `ST_SHOW`: selected retrace, output high.
- `ST_HIDE`: unselected retrace, output low.

Its transitions are:
- WAIT→QUAL on a low sample.
- QUAL→WAIT on a high sample (glitch rejected).
- QUAL→SHOW or QUAL→HIDE when the count reaches the limit, according to the field select (accept).
- SHOW→WAIT and HIDE→WAIT on a high sample (release).

Top module: `field_retrace_sel`

## Requirements
- R1: During and after reset `retrace_out` is low until a retrace is accepted. The internal field tracker is cleared, so the first accepted retrace after reset counts as odd.
- R2: `vsync_n_in` and `field_odd_in` each pass through SYNC_STAGES (default 2) flip-flops before use. Let L = max(`min_low_clks`, 1). If `vsync_n_in` goes low just before clock edge k and stays low, a selected retrace raises `retrace_out` right after edge k+L+2.
- R3: A low interval of `vsync_n_in` covering N sampling edges with N ≤ L produces no output and does not advance the field tracker.
- R4: Once raised, `retrace_out` stays high until `vsync_n_in` returns high. If edge k+N is the first edge to see it high, the output falls right after edge k+N+2, so it is high for N−L cycles.
- R5: With `use_ext_field`=0 the tracker flips on each accepted retrace; its value after the flip is the field, 1 meaning odd and 0 even. `pass_odd`=1 passes the odd retraces (1st, 3rd, ... after reset) and `pass_odd`=0 the even ones, so exactly one of two consecutive accepted retraces is output.
- R6: With `use_ext_field`=1 the synchronized `field_odd_in` (1 = odd) at the accepting cycle decides the field, and the tracker is ignored.
- R7: An accepted retrace of the unselected field keeps `retrace_out` low for its whole interval.
- R8: A `min_low_clks` value of 0 behaves exactly like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_n_in | input | 1 | Asynchronous vertical sync, low during retrace |
| field_odd_in | input | 1 | Asynchronous external field indication, 1 = odd |
| use_ext_field | input | 1 | Static: 1 selects the external field, 0 the internal tracker |
| pass_odd | input | 1 | Static: 1 passes odd-field retraces, 0 even-field |
| min_low_clks | input | CNT_W | Minimum low length; longer intervals are accepted |
| retrace_out | output | 1 | High during the selected, accepted retrace |

## Verification
On every cycle the assertions check four things:
- a rejected glitch never raises the output;
- a high sync sample always ends a shown retrace;
- the output only rises after a low sample;
- the field tracker flips exactly on acceptances, and the internally tracked field of every shown retrace matches `pass_odd`.

Only the bench scenarios can show the rest. These are the exact rise and fall cycles against L, the boundary between N = L and N = L+1, and the alternation of passed and hidden retraces over a long sequence. They also cover the equivalence of limit 0 and 1 and the external field path.

// File: rtl/frs_pkg.sv
package frs_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_QUAL = 2'd1,
        ST_SHOW = 2'd2,
        ST_HIDE = 2'd3
    } frs_state_e;
endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/frs_retrace_fsm.sv
module frs_retrace_fsm
    import frs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_low,
    input  logic [CNT_W-1:0] min_len,
    input  logic             pass_sel,
    output logic             accept,
    output logic             active
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    frs_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             reached;

    assign lim     = (min_len == '0) ? ONE : min_len;
    assign reached = (cnt >= lim);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // low-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= ONE;
        end else if (state == ST_WAIT) begin
            cnt <= ONE;
        end else if (state == ST_QUAL && vs_low && !reached) begin
            cnt <= cnt + ONE;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: if (vs_low) nxt = ST_QUAL;
            ST_QUAL: begin
                if (!vs_low)      nxt = ST_WAIT;
                else if (reached) nxt = pass_sel ? ST_SHOW : ST_HIDE;
            end
            ST_SHOW: if (!vs_low) nxt = ST_WAIT;
            ST_HIDE: if (!vs_low) nxt = ST_WAIT;
            default: nxt = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        accept = (state == ST_QUAL) && vs_low && reached;
        active = (state == ST_SHOW);
    end

    AST_GLITCH_NO_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL && !vs_low) |=> !active); // R3
    AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !vs_low) |=> !active); // R4
    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(vs_low)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL) |-> (cnt <= lim)); // R8
endmodule

// File: rtl/frs_field_track.sv
module frs_field_track (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic use_ext,
    input  logic ext_odd,
    input  logic sel_odd,
    output logic odd_now,
    output logic pass_sel
);
    logic tog_q;
    logic parity;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tog_q <= 1'b0;
        else if (accept) tog_q <= ~tog_q;
    end

    // parity of the retrace being accepted this cycle
    assign parity   = use_ext ? ext_odd : ~tog_q;
    assign pass_sel = (parity == sel_odd);
    assign odd_now  = tog_q;

    AST_TOGGLE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tog_q != $past(tog_q))); // R5
    AST_HOLD_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(tog_q)); // R3
endmodule

// File: rtl/field_retrace_sel.sv
module field_retrace_sel #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_n_in,
    input  logic             field_odd_in,
    input  logic             use_ext_field,
    input  logic             pass_odd,
    input  logic [CNT_W-1:0] min_low_clks,
    output logic             retrace_out
);
    logic vs_n_s;
    logic fld_s;
    logic accept;
    logic pass_sel;
    logic odd_now;
    logic active;

    frs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_vs_sync (
        .clk(clk), .rst_n(rst_n), .d(vsync_n_in), .q(vs_n_s));

    frs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_fld_sync (
        .clk(clk), .rst_n(rst_n), .d(field_odd_in), .q(fld_s));

    frs_retrace_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .vs_low(~vs_n_s), .min_len(min_low_clks),
        .pass_sel(pass_sel), .accept(accept), .active(active));

    frs_field_track u_track (
        .clk(clk), .rst_n(rst_n), .accept(accept), .use_ext(use_ext_field),
        .ext_odd(fld_s), .sel_odd(pass_odd), .odd_now(odd_now), .pass_sel(pass_sel));

    assign retrace_out = active;

    AST_SHOWN_FIELD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(retrace_out) && !use_ext_field) |-> (odd_now == pass_odd)); // R5
    AST_SHOWN_EXT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(retrace_out) && use_ext_field) |-> ($past(fld_s) == pass_odd)); // R6
endmodule

// File: tb/test_field_retrace_sel.sv
`timescale 1ns/1ps
module test_field_retrace_sel;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vsync_n = 1'b1;
    logic          fld = 1'b0;
    logic          use_ext = 1'b0;
    logic          sel = 1'b1;
    logic [CW-1:0] minl = 8'd2;
    logic          out;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int parity = 0; // bench model of internal field (1 = odd)

    always #5 clk = ~clk;

    field_retrace_sel #(.SYNC_STAGES(2), .CNT_W(CW)) i_field_retrace_sel (
        .clk(clk), .rst_n(rst_n), .vsync_n_in(vsync_n), .field_odd_in(fld),
        .use_ext_field(use_ext), .pass_odd(sel), .min_low_clks(minl),
        .retrace_out(out));

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one low interval of n sampling edges; bench computes expected result
    task automatic pulse(int n, int m, string tag);
        int  first = -1;
        int  cnt = 0;
        int  lim = (m == 0) ? 1 : m;
        bit  acc = (n > lim);
        bit  show;
        if (acc) parity = 1 - parity;
        show = acc && (use_ext ? (fld == sel) : (parity == int'(sel)));
        @(negedge clk);
        vsync_n = 1'b0;
        for (int i = 0; i < n + 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (out) begin
                cnt++;
                if (first < 0) first = i;
            end
            if (i == n - 1) vsync_n = 1'b1;
        end
        chk({tag, " R4 high-cycles"}, cnt, show ? (n - lim) : 0);
        chk({tag, " R2 rise-offset"}, first, show ? (lim + 2) : -1);
        chk({tag, " R4 low-after"}, int'(out), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog R1 actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int ms[5] = '{0, 1, 2, 3, 6};
        repeat (3) @(negedge clk);
        chk("R1 out in reset", int'(out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 out after reset", int'(out), 0);

        // R1: first accepted retrace after reset is odd
        minl = 8'd2; sel = 1'b1;
        pulse(5, 2, "R1 first-odd");

        // R3, R5, R7, R8: sweep limits, selects and lengths
        foreach (ms[k]) begin
            for (int s = 0; s < 2; s++) begin
                sel  = s[0];
                minl = CW'(ms[k]);
                for (int n = 1; n <= 9; n++) begin
                    string t;
                    int    lim = (ms[k] == 0) ? 1 : ms[k];
                    t = (n <= lim) ? "R3" : ((ms[k] == 0) ? "R8" : "R5/R7");
                    pulse(n, ms[k], t);
                end
            end
        end

        // R6: external field path
        use_ext = 1'b1;
        minl = 8'd2;
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 2; f++) begin
                sel = s[0];
                fld = f[0];
                repeat (4) @(negedge clk);
                pulse(5, 2, "R6 ext");
                pulse(6, 2, "R6 ext-repeat");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule